// File: doc/BRIEF.md
# AC-Coupled Boundary-Scan Pulse Driver

This block extends an output boundary-scan cell so that a pin can be tested across AC-coupled or differential interconnect. A plain static level cannot cross a coupling capacitor: the receiving side only sees edges. The driver therefore takes the test value from the update stage, the decoded instruction class and two TAP state indications. In the AC classes it adds edges on the pin while the TAP controller stays in Run-Test/Idle, so an edge-sensing receiver downstream can rebuild the value. It does this even when the test bit has not changed since the last update.

Four instruction classes are supplied on `mode`:
- `2'b00` selects mission data.
- `2'b01` selects static level test.
- `2'b10` selects single pulse.
- `2'b11` selects pulse train.

A five-state machine generates the edges. It is clocked on the falling edge of TCK, which is when a TAP drives outputs. The states are:
- `ST_HOLD`: drive equals the test value.
- `ST_INV`: a one-period inversion in pulse mode.
- `ST_SETTLE`: back on the test value for the rest of the Run-Test/Idle stay.
- `ST_TRAIN_HI` and `ST_TRAIN_LO`: the inverted and true phases of the train.

The state transitions are:
- `ST_HOLD` goes to `ST_INV` (pulse class) or to `ST_TRAIN_HI` (train class) when Run-Test/Idle is seen.
- `ST_INV` goes to `ST_SETTLE` while Run-Test/Idle persists, otherwise to `ST_HOLD`.
- `ST_SETTLE` stays put while Run-Test/Idle persists, otherwise returns to `ST_HOLD`.
- `ST_TRAIN_HI` and `ST_TRAIN_LO` alternate while Run-Test/Idle persists, and either one returns to `ST_HOLD` when it ends.
- Every state returns to `ST_HOLD` on Update-DR, on a class that is not AC, or on reset.

The complementary pin of a differential pair is always the inverse of the single-ended drive.

Top module: `acpd_pulse_driver`

## Requirements
- R1: With `mode` = 2'b00, `pin_p` equals `mission_val` at all times, whatever `in_rti` does.
- R2: With `mode` = 2'b01, `pin_p` equals `test_val` as a static level and shows no extra edges during Run-Test/Idle.
- R3: With `mode` = 2'b10, the first falling TCK edge that sees `in_rti` high from `ST_HOLD` makes `pin_p` the inverse of `test_val` for exactly one TCK period. After that period `pin_p` returns to `test_val`, giving two edges even if the test value is unchanged.
- R4: With `mode` = 2'b10, only one pulse is produced per Run-Test/Idle stay. `pin_p` stays on `test_val` until Run-Test/Idle is left.
- R5: With `mode` = 2'b11, `pin_p` toggles on every falling TCK edge while `in_rti` is high. It starts with the inverse of `test_val`.
- R6: With `mode` = 2'b11, the first falling edge with `in_rti` low puts `pin_p` back on `test_val`, from either train phase.
- R7: `pin_n` is the bitwise complement of `pin_p` at all times.
- R8: A falling edge with `in_update_dr` high returns the sequencer to `ST_HOLD`, so `pin_p` equals `test_val`. A later Run-Test/Idle stay re-arms the pulse.
- R9: While `trst_n` is low, the sequencer is in `ST_HOLD` and an AC class drives `test_val` without inversion.
- R10: A change to a non-AC class returns the sequencer to `ST_HOLD`. Going back to the train class then restarts the train from its inverted phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the sequencer advances on its falling edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| mode | input | 2 | Instruction class: 00 mission, 01 level, 10 pulse, 11 train |
| test_val | input | 1 | Test bit from the update stage of the cell |
| mission_val | input | 1 | Functional data from the core |
| in_rti | input | 1 | TAP controller is in Run-Test/Idle |
| in_update_dr | input | 1 | TAP controller is in Update-DR |
| pin_p | output | 1 | Single-ended / true-side pin drive |
| pin_n | output | 1 | Complement-side pin drive |

## Verification
A wrong sequencer state shows directly on `pin_p` in the half period after the falling TCK edge that entered it. For example, an inversion that outlives one period, a train that stops alternating, or a pulse that repeats inside one Run-Test/Idle stay each shows on the pin within one TCK cycle. The bench therefore compares every pin value once per cycle, after the falling edge, against a value it derives from the class, the test bit and the Run-Test/Idle history. It also compares `pin_n` against the inverse of `pin_p` on every sample.

// File: rtl/acpd_pkg.sv
package acpd_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_MISSION = 2'b00,
        MD_LEVEL   = 2'b01,
        MD_PULSE   = 2'b10,
        MD_TRAIN   = 2'b11
    } acpd_mode_e;

    typedef enum logic [2:0] {
        ST_HOLD     = 3'd0,
        ST_INV      = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_TRAIN_HI = 3'd3,
        ST_TRAIN_LO = 3'd4
    } acpd_state_e;

endpackage

// File: rtl/acpd_seq.sv
module acpd_seq
    import acpd_pkg::*;
(
    input  logic        tck,
    input  logic        trst_n,
    input  acpd_mode_e  mode,
    input  logic        in_rti,
    input  logic        in_update_dr,
    output acpd_state_e st,
    output logic        invert
);

    acpd_state_e st_next;
    logic        ac_class;

    assign ac_class = (mode == MD_PULSE) || (mode == MD_TRAIN);

    // state register: falling TCK, like every TAP-driven output
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) st <= ST_HOLD;
        else         st <= st_next;
    end

    always_comb begin
        st_next = st;
        if (in_update_dr || !ac_class) begin
            st_next = ST_HOLD;
        end else begin
            unique case (st)
                ST_HOLD:     if (in_rti) st_next = (mode == MD_PULSE) ? ST_INV : ST_TRAIN_HI;
                ST_INV:      st_next = in_rti ? ST_SETTLE : ST_HOLD;
                ST_SETTLE:   st_next = in_rti ? ST_SETTLE : ST_HOLD;
                ST_TRAIN_HI: st_next = in_rti ? ST_TRAIN_LO : ST_HOLD;
                ST_TRAIN_LO: st_next = in_rti ? ST_TRAIN_HI : ST_HOLD;
                default:     st_next = ST_HOLD;
            endcase
        end
    end

    // output decode: inversion phases only
    always_comb begin
        unique case (st)
            ST_INV, ST_TRAIN_HI: invert = 1'b1;
            default:             invert = 1'b0;
        endcase
    end

endmodule

// File: rtl/acpd_drive.sv
module acpd_drive
    import acpd_pkg::*;
(
    input  acpd_mode_e mode,
    input  logic       test_val,
    input  logic       mission_val,
    input  logic       invert,
    output logic       drive
);

    always_comb begin
        unique case (mode)
            MD_MISSION:        drive = mission_val;
            MD_LEVEL:          drive = test_val;
            MD_PULSE, MD_TRAIN: drive = test_val ^ invert;
            default:           drive = test_val;
        endcase
    end

endmodule

// File: rtl/acpd_pulse_driver.sv
module acpd_pulse_driver
    import acpd_pkg::*;
(
    input  logic                tck,
    input  logic                trst_n,
    input  logic [MODE_W-1:0]   mode,
    input  logic                test_val,
    input  logic                mission_val,
    input  logic                in_rti,
    input  logic                in_update_dr,
    output logic                pin_p,
    output logic                pin_n
);

    acpd_mode_e  mode_e;
    acpd_state_e st;
    logic        invert;
    logic        drive;

    assign mode_e = acpd_mode_e'(mode);

    acpd_seq seq_i (
        .tck          (tck),
        .trst_n       (trst_n),
        .mode         (mode_e),
        .in_rti       (in_rti),
        .in_update_dr (in_update_dr),
        .st           (st),
        .invert       (invert)
    );

    acpd_drive drv_i (
        .mode        (mode_e),
        .test_val    (test_val),
        .mission_val (mission_val),
        .invert      (invert),
        .drive       (drive)
    );

    assign pin_p = drive;
    assign pin_n = ~drive;

endmodule

// File: rtl/acpd_pulse_driver_chk.sv
module acpd_pulse_driver_chk
    import acpd_pkg::*;
(
    input logic              tck,
    input logic              trst_n,
    input logic [MODE_W-1:0] mode,
    input logic              test_val,
    input logic              mission_val,
    input logic              in_rti,
    input logic              in_update_dr,
    input logic              pin_p,
    input logic              pin_n,
    input acpd_state_e       st
);

    assert_diff_pair_R7: assert property (@(negedge tck) disable iff (!trst_n)
        pin_n == !pin_p);

    assert_mission_pass_R1: assert property (@(negedge tck) disable iff (!trst_n)
        (mode == 2'b00) |-> (pin_p == mission_val));

    assert_level_static_R2: assert property (@(negedge tck) disable iff (!trst_n)
        (mode == 2'b01) |-> (pin_p == test_val));

    assert_pulse_one_period_R3: assert property (@(negedge tck) disable iff (!trst_n)
        (st == ST_INV) |=> (st != ST_INV));

    assert_pulse_inverted_R3: assert property (@(negedge tck) disable iff (!trst_n)
        (st == ST_INV && mode == 2'b10) |-> (pin_p != test_val));

    assert_single_pulse_R4: assert property (@(negedge tck) disable iff (!trst_n)
        (st == ST_SETTLE && in_rti && !in_update_dr && mode == 2'b10) |=> (st == ST_SETTLE));

    assert_train_toggle_R5: assert property (@(negedge tck) disable iff (!trst_n)
        (st == ST_TRAIN_HI && in_rti && !in_update_dr && mode == 2'b11) |=> (st == ST_TRAIN_LO));

    assert_train_exit_R6: assert property (@(negedge tck) disable iff (!trst_n)
        ((st == ST_TRAIN_HI || st == ST_TRAIN_LO) && !in_rti) |=> (st == ST_HOLD));

    assert_update_hold_R8: assert property (@(negedge tck) disable iff (!trst_n)
        in_update_dr |=> (st == ST_HOLD));

endmodule

bind acpd_pulse_driver acpd_pulse_driver_chk chk_i (
    .tck          (tck),
    .trst_n       (trst_n),
    .mode         (mode),
    .test_val     (test_val),
    .mission_val  (mission_val),
    .in_rti       (in_rti),
    .in_update_dr (in_update_dr),
    .pin_p        (pin_p),
    .pin_n        (pin_n),
    .st           (st)
);

// File: tb/acpd_pulse_driver_tb_top.sv
`timescale 1ns/1ps
module acpd_pulse_driver_tb_top;

    typedef struct {
        logic  exp;
        string req;
    } exp_item_t;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       test_val = 1'b0;
    logic       mission_val = 1'b0;
    logic       in_rti = 1'b0;
    logic       in_update_dr = 1'b0;
    logic       pin_p;
    logic       pin_n;

    exp_item_t  q[$];
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 tck = ~tck;

    acpd_pulse_driver dut_i (
        .tck          (tck),
        .trst_n       (trst_n),
        .mode         (mode),
        .test_val     (test_val),
        .mission_val  (mission_val),
        .in_rti       (in_rti),
        .in_update_dr (in_update_dr),
        .pin_p        (pin_p),
        .pin_n        (pin_n)
    );

    // driver: apply one cycle of stimulus and queue the expected pin value
    task automatic step(input logic [1:0] md, input logic tv, input logic mv,
                        input logic rti, input logic upd, input logic exp, input string req);
        exp_item_t it;
        @(posedge tck);
        #1;
        mode = md; test_val = tv; mission_val = mv; in_rti = rti; in_update_dr = upd;
        it.exp = exp;
        it.req = req;
        q.push_back(it);
    endtask

    // monitor: sample after the falling edge, compare with the queue head
    initial begin
        forever begin
            @(negedge tck);
            #1;
            if (q.size() > 0) begin
                exp_item_t it;
                it = q.pop_front();
                n_checks++;
                if (pin_p !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s pin_p actual=%b expected=%b", it.req, pin_p, it.exp);
                end
                n_checks++;
                if (pin_n !== ~it.exp) begin
                    n_fail++;
                    $display("FAIL R7 pin_n actual=%b expected=%b", pin_n, ~it.exp);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset holds the sequencer; AC class drives the plain value
        step(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        @(posedge tck); #1; trst_n = 1'b1;
        // R1: mission passthrough, Run-Test/Idle ignored
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        step(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        step(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
        // R2: level class stays static during Run-Test/Idle
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        // R3/R4: single pulse with test value 1
        step(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
        step(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        step(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        step(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        step(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        step(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
        // R8: update to value 0, then pulse again
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        // R8: update in the middle of a stay re-arms the pulse
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        // R5/R6: train with test value 0, exit from inverted phase
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        // R6: train with value 1, exit from true phase
        step(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        step(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        // R10: class change mid-train restarts from inverted phase
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
        step(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
        step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        repeat (3) @(posedge tck);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule